// File: doc/BRIEF.md
# Decode Group Steering Unit

This block sits between the instruction aligner and the micro-op generators. The aligner presents up to three instructions each cycle. Each instruction comes with a valid bit and a precomputed micro-op count. The unit decides which of them enter decode this cycle and where each one goes:

- the general decoder, which takes up to four micro-ops;
- one of two single-micro-op decoders;
- the long-sequence engine.

The unit keeps program order throughout. A decode group ends early at the first instruction that does not fit the next free slot. The unit reports how many instructions it took, so the aligner can drop exactly that many from the head of its queue.

When the leading instruction expands to more than four micro-ops, it is handed alone to the sequencer. The sequencer releases its micro-ops in chunks of at most four per cycle. While it still has micro-ops left over after that first cycle, the unit raises busy and takes nothing new. The lane count, the count width, the general-slot limit and the sequencer rate are all parameters.

Top module: `vls_steer_top`

## Requirements
- R1: During reset and in the first cycle after it, with no valid input, busy is 0, seq_uops is 0, consumed is 0 and every route field is NONE.
- R2: When lane 0 is not valid, consumed is 0 and all route fields are NONE. This holds whatever the other lanes carry.
- R3: The route of lane i is the 2-bit field at bits [2i+1:2i], coded as NONE=0, GEN=1, SIMPLE=2, SEQ=3. When the unit is idle and lane 0 is valid with a count of 0 to 4, lane 0 is routed GEN.
- R4: Lane 1 is routed SIMPLE only if lane 0 went to GEN and lane 1 is valid with a count of exactly 1. Lane 2 is routed SIMPLE only if lane 1 did so and lane 2 is valid with a count of exactly 1. The consumed output equals the number of lanes whose route is not NONE.
- R5: The group ends at the first lane that is invalid or whose count is not 1. No later lane is routed, even when that later lane would fit a single-micro-op slot.
- R6: An idle unit given a valid lane 0 with more than 4 micro-ops does all of the following in that cycle:
  - routes lane 0 SEQ;
  - routes lanes 1 and 2 NONE;
  - reports consumed = 1;
  - reports seq_uops = 4.
- R7: After an SEQ hand-off, busy is 1 in each later cycle in which micro-ops remain. In such a cycle seq_uops is the smaller of 4 and the remainder. Busy returns to 0 in the cycle after the last chunk, so a count of N holds busy for ceil(N/4)-1 cycles.
- R8: While busy is 1, consumed is 0 and all route fields are NONE, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 3 | Per-lane valid, bit 0 is oldest |
| in_uops | input | 18 | Per-lane micro-op count, 6 bits each, lane 0 in bits [5:0] |
| route | output | 6 | Per-lane destination code, 2 bits per lane |
| consumed | output | 2 | Instructions taken this cycle (0 to 3) |
| busy | output | 1 | Sequencer still emitting a long expansion |
| seq_uops | output | 6 | Micro-ops the sequencer emits this cycle |

## Verification
A wrong remainder in the sequencer shows at the ports in one of two ways, both within the cycles of the expansion itself:

- busy stays high one cycle too long or drops one cycle too early;
- seq_uops on the final chunk differs from the remainder left by the count.

A break in the steering chain shows in the same cycle as a route field or a consumed count that disagrees with the prefix of single-micro-op lanes. The bench therefore compares every output in every cycle against its own model, so a fault surfaces in the first cycle that exercises it.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [1:0] {
    RT_NONE   = 2'd0,
    RT_GEN    = 2'd1,
    RT_SIMPLE = 2'd2,
    RT_SEQ    = 2'd3
  } route_e;

  // An instruction is long when it exceeds the general slot's capacity.
  function automatic logic is_long(input int unsigned uops, input int unsigned gen_max);
    return uops > gen_max;
  endfunction

  // Single-micro-op slots accept only a count of exactly one.
  function automatic logic fits_simple(input int unsigned uops);
    return uops == 1;
  endfunction

  // Micro-ops the sequencer can release from a remainder in one cycle.
  function automatic int unsigned seq_chunk(input int unsigned rem, input int unsigned rate);
    return (rem > rate) ? rate : rem;
  endfunction
endpackage

// File: rtl/vls_group.sv
module vls_group
  import vls_pkg::*;
#(
  parameter int LANES   = 3,
  parameter int UOP_W   = 6,
  parameter int GEN_MAX = 4,
  localparam int CW     = $clog2(LANES + 1)
) (
  input  logic                   busy,
  input  logic [LANES-1:0]       valid,
  input  logic [LANES*UOP_W-1:0] uops,
  output logic [2*LANES-1:0]     route,
  output logic [CW-1:0]          consumed,
  output logic                   seq_take,
  output logic [UOP_W-1:0]       lead_uops
);
  logic [LANES-1:0] taken;
  logic             lead_take;
  logic             lead_long;
  logic [LANES-1:0] chain;

  assign lead_uops = uops[UOP_W-1:0];
  assign lead_take = valid[0] && !busy;
  assign lead_long = is_long(int'(lead_uops), GEN_MAX);
  assign seq_take  = lead_take && lead_long;
  assign chain[0]  = lead_take && !lead_long;
  assign taken[0]  = lead_take;
  assign route[1:0] = !lead_take ? RT_NONE : (lead_long ? RT_SEQ : RT_GEN);

  for (genvar i = 1; i < LANES; i++) begin : g_lane
    logic [UOP_W-1:0] lane_uops;
    assign lane_uops = uops[i*UOP_W +: UOP_W];
    assign chain[i]  = chain[i-1] && valid[i] && fits_simple(int'(lane_uops));
    assign taken[i]  = chain[i];
    assign route[2*i +: 2] = chain[i] ? RT_SIMPLE : RT_NONE;
  end

  always_comb begin
    consumed = '0;
    for (int i = 0; i < LANES; i++)
      consumed = consumed + CW'(taken[i]);
  end

  // R5: a lane is only taken when every older lane was taken too.
  always_comb begin
    for (int i = 1; i < LANES; i++)
      a_r5_prefix: assert (!taken[i] || taken[i-1]);
  end
endmodule

// File: rtl/vls_seq.sv
module vls_seq
  import vls_pkg::*;
#(
  parameter int UOP_W = 6,
  parameter int RATE  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [UOP_W-1:0] start_uops,
  output logic             busy,
  output logic [UOP_W-1:0] emit
);
  logic [UOP_W-1:0] rem_q;
  logic [UOP_W-1:0] rem_chunk;
  logic [UOP_W-1:0] start_chunk;

  assign busy        = rem_q != '0;
  assign rem_chunk   = UOP_W'(seq_chunk(int'(rem_q), RATE));
  assign start_chunk = UOP_W'(seq_chunk(int'(start_uops), RATE));

  always_comb begin
    if (start)     emit = start_chunk;
    else if (busy) emit = rem_chunk;
    else           emit = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rem_q <= '0;
    else if (start)  rem_q <= start_uops - start_chunk;
    else if (busy)   rem_q <= rem_q - rem_chunk;
  end

  // R7: the sequencer never releases more than its rate in a cycle.
  a_r7_rate_cap: assert property (@(posedge clk) disable iff (!rst_n)
    emit <= UOP_W'(RATE));
  // R7: a remainder that fits in one chunk ends the busy phase next cycle.
  a_r7_last_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && emit == rem_q) |=> !busy);
  // R8: a new hand-off never overlaps an active expansion.
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/vls_steer_top.sv
module vls_steer_top
  import vls_pkg::*;
#(
  parameter int LANES   = 3,
  parameter int UOP_W   = 6,
  parameter int GEN_MAX = 4,
  parameter int RATE    = 4,
  localparam int CW     = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       in_valid,
  input  logic [LANES*UOP_W-1:0] in_uops,
  output logic [2*LANES-1:0]     route,
  output logic [CW-1:0]          consumed,
  output logic                   busy,
  output logic [UOP_W-1:0]       seq_uops
);
  logic             seq_take_w;
  logic [UOP_W-1:0] lead_uops_w;

  vls_group #(.LANES(LANES), .UOP_W(UOP_W), .GEN_MAX(GEN_MAX)) u_group (
    .busy      (busy),
    .valid     (in_valid),
    .uops      (in_uops),
    .route     (route),
    .consumed  (consumed),
    .seq_take  (seq_take_w),
    .lead_uops (lead_uops_w)
  );

  vls_seq #(.UOP_W(UOP_W), .RATE(RATE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (seq_take_w),
    .start_uops (lead_uops_w),
    .busy       (busy),
    .emit       (seq_uops)
  );

  // R2: nothing is consumed without a valid lead instruction.
  a_r2_no_lead: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid[0] |-> (consumed == '0));
  // R6: a hand-off to the sequencer takes exactly one instruction.
  a_r6_alone: assert property (@(posedge clk) disable iff (!rst_n)
    seq_take_w |-> (consumed == CW'(1)));
  // R6/R7: busy follows whether the hand-off left a remainder.
  a_r7_busy_after: assert property (@(posedge clk) disable iff (!rst_n)
    seq_take_w |=> (busy == ($past(lead_uops_w) > UOP_W'(RATE))));
  // R8: busy blocks all intake.
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (consumed == '0 && route == '0));
endmodule

// File: tb/vls_steer_top_test.sv
module vls_steer_top_test;
  localparam int LANES = 3;
  localparam int UW    = 6;

  logic             clk = 0;
  logic             rst_n = 0;
  logic [LANES-1:0] in_valid = '0;
  logic [LANES*UW-1:0] in_uops = '0;
  logic [5:0]       route;
  logic [1:0]       consumed;
  logic             busy;
  logic [UW-1:0]    seq_uops;

  int checks = 0;
  int fails  = 0;
  int rem_m  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  vls_steer_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
    .route(route), .consumed(consumed), .busy(busy), .seq_uops(seq_uops)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int lane_u(input int i);
    return int'(in_uops[i*UW +: UW]);
  endfunction

  // Drive at the falling edge, compare before the rising edge, then advance the model.
  task automatic step(input logic [2:0] v, input int u0, input int u1, input int u2);
    int exp_route, exp_cons, exp_emit, exp_busy, n;
    string tag;
    @(negedge clk);
    in_valid = v;
    in_uops  = {UW'(u2), UW'(u1), UW'(u0)};
    #2;
    exp_busy = (rem_m != 0);
    exp_route = 0; exp_cons = 0; exp_emit = 0;
    if (exp_busy) begin
      tag = "R8";
      exp_emit = (rem_m > 4) ? 4 : rem_m;
      rem_m -= exp_emit;
    end else if (!v[0]) begin
      tag = "R2";
    end else if (u0 > 4) begin
      tag = "R6";
      exp_route = 3; exp_cons = 1;
      exp_emit = 4; rem_m = u0 - 4;
    end else begin
      tag = "R4";
      exp_route = 1; n = 1;
      while (n < 3 && v[n] && lane_u(n) == 1) begin
        exp_route |= 2 << (2*n);
        n++;
      end
      exp_cons = n;
      if (n < 3) tag = "R5";
      if (n == 1) tag = "R3";
    end
    chk(tag, "route", int'(route), exp_route);
    chk(tag, "consumed", int'(consumed), exp_cons);
    chk(exp_busy ? "R7" : tag, "busy", int'(busy), exp_busy);
    chk(exp_busy ? "R7" : tag, "seq_uops", int'(seq_uops), exp_emit);
  endtask

  function automatic int rnd_u();
    int r = int'($urandom_range(0, 99));
    if (r < 55) return 1;
    if (r < 75) return int'($urandom_range(2, 4));
    if (r < 80) return 0;
    return int'($urandom_range(5, 63));
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "seq_uops", int'(seq_uops), 0);
    chk("R1", "consumed", int'(consumed), 0);
    @(negedge clk); rst_n = 1;
    step(3'b000, 0, 0, 0);
    chk("R1", "route", int'(route), 0);

    // Directed corners
    step(3'b111, 1, 1, 1);   // R4 full group
    step(3'b111, 4, 1, 1);   // R3 four-uop lead
    step(3'b111, 0, 1, 1);   // R3 zero count goes GEN
    step(3'b111, 2, 2, 1);   // R5 stops at lane 1
    step(3'b101, 1, 1, 1);   // R5 gap at lane 1 blocks lane 2
    step(3'b111, 1, 1, 3);   // R5 stops at lane 2
    step(3'b110, 5, 1, 1);   // R2 lead invalid
    step(3'b111, 5, 1, 1);   // R6 five uops
    step(3'b111, 1, 1, 1);   // R7/R8 last chunk of 1
    step(3'b111, 1, 1, 1);   // back to idle
    step(3'b111, 8, 1, 1);   // R6 exactly two chunks
    step(3'b111, 1, 1, 1);
    step(3'b001, 63, 0, 0);  // R7 long drain
    for (int k = 0; k < 16; k++) step(3'b111, 1, 1, 1);
    step(3'b001, 9, 0, 0);
    repeat (4) step(3'b011, 1, 1, 0);

    // Constrained random
    for (int k = 0; k < 3000; k++)
      step(3'($urandom_range(0, 7) | ($urandom_range(0, 3) != 0 ? 1 : 0)),
           rnd_u(), rnd_u(), rnd_u());

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule